// File: doc/BRIEF.md
# Widening Multiply-Accumulate Operand Preparation Unit

This block is the front end of a vector multiply-accumulate that widens half-precision products into single-precision accumulators. It receives two 128-bit source registers and a small configuration: the operation width, which half of the sources to use, whether the operation subtracts, and whether the second operand is one element broadcast to all lanes. From these it builds up to four pairs of single-precision multiplicands, one pair for each 32-bit accumulator lane, and a mask of the lanes that are active.

Each half-precision element is widened by an exact bit-level conversion. This conversion raises no exceptions and keeps infinities and NaNs, including signalling NaNs, with their payloads. Subnormal half values become normal single values, unless the flush-to-zero control is set. In that case they become signed zeros. The subtract variant negates the first operand by inverting the sign of each half element before widening. The sources are captured into output registers on the cycle the request is accepted. A destination that aliases a source therefore cannot disturb the operands. Inactive lanes carry zero operands and a clear mask bit, so downstream logic can zero those accumulator lanes.

Top module: `wmac_prep`

## Requirements
- R1: `out_valid` is high in the cycle after a cycle with `in_valid` high, and low in the cycle after a cycle with `in_valid` low. Reset clears `out_valid`, `lane_mask`, `mul_a` and `mul_b`.
- R2: `lane_mask` is 4'b1111 when `wide`=1 (16-byte width) and 4'b0011 when `wide`=0 (8-byte width). Bit i marks lane i.
- R3: With `wide`=1 the elements come from source bits 127:64 if `upper`=1 and from bits 63:0 if `upper`=0. With `wide`=0 they come from bits 63:32 if `upper`=1 and from bits 31:0 if `upper`=0.
- R4: Lane i takes bits 16i+15:16i of the selected group. Its single-precision results sit at `mul_a`/`mul_b` bits 32i+31:32i.
- R5: When `sub`=1, bit 15 of every selected first-operand element is inverted before widening. The second operand is unchanged.
- R6: When `indexed`=1, element `idx` of `src_b` (bits 16·idx+15:16·idx) is widened and used as `mul_b` in every active lane.
- R7: Lanes whose mask bit is 0 output zero in both `mul_a` and `mul_b`.
- R8: A half with exponent 31 maps to single exponent 255, with the sign and the 10-bit fraction kept in the top fraction bits. A half with exponent 1..30 maps to exponent+112. A zero keeps its sign. The low 13 fraction bits are always zero.
- R9: A subnormal half (exponent 0, fraction nonzero) widens to the exact normalized single value when `ftz`=0, and to a zero of the same sign when `ftz`=1.
- R10: The outputs change only on a cycle with `in_valid` high. Changes to the sources while `in_valid` is low have no effect on them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe; sources and configuration are captured |
| src_a | input | 128 | First source register |
| src_b | input | 128 | Second source register |
| wide | input | 1 | 1: 16-byte width, four lanes; 0: 8-byte width, two lanes |
| upper | input | 1 | Selects the upper group of elements |
| sub | input | 1 | Subtract variant: negate first operand |
| indexed | input | 1 | Broadcast one element of `src_b` |
| idx | input | 3 | Element index for indexed mode |
| ftz | input | 1 | Flush subnormal inputs to zero |
| out_valid | output | 1 | Operands valid |
| lane_mask | output | 4 | Active lane mask |
| mul_a | output | 128 | First multiplicands, four 32-bit lanes |
| mul_b | output | 128 | Second multiplicands, four 32-bit lanes |

## Verification
Every one of the 65536 half-precision codes is passed through the datapath, once with flush-to-zero off and once with it on. This separates normal, infinite, NaN, zero and subnormal handling, and it shows the difference between normalization and flushing on the subnormal codes. A second sweep walks all combinations of width, upper/lower select, subtract, indexed mode and all eight index values. Each source element carries a distinct value, so a wrong group, a wrong lane order, a wrong broadcast element or a misplaced sign flip produces a visible mismatch. Idle cycles with scrambled sources show that the outputs are held and that valid drops.

// File: rtl/wmac_prep.sv
module wmac_prep #(
  parameter int LANES = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [127:0]        src_a,
  input  logic [127:0]        src_b,
  input  logic                wide,
  input  logic                upper,
  input  logic                sub,
  input  logic                indexed,
  input  logic [2:0]          idx,
  input  logic                ftz,
  output logic                out_valid,
  output logic [LANES-1:0]    lane_mask,
  output logic [32*LANES-1:0] mul_a,
  output logic [32*LANES-1:0] mul_b
);
  localparam int GW = 16 * LANES;

  function automatic logic [31:0] h2s(input logic [15:0] h, input logic fz);
    logic [4:0] e;
    logic [9:0] f;
    logic [9:0] fo;
    logic [7:0] eo;
    int         sh;
    e = h[14:10];
    f = h[9:0];
    fo = f;
    sh = 0;
    if (e == 5'h1f) begin
      eo = 8'hff;
    end else if (e == 5'h00) begin
      eo = 8'h00;
      if (f != 10'd0) begin
        if (fz) begin
          fo = 10'd0;
        end else begin
          for (int k = 0; k < 10; k++)
            if (f[k]) sh = 10 - k;
          fo = f << sh;
          eo = 8'(113 - sh);
        end
      end
    end else begin
      eo = 8'({3'b000, e} + 8'd112);
    end
    return {h[15], eo, fo, 13'd0};
  endfunction

  logic [GW-1:0]          grp_a, grp_b;
  logic [LANES-1:0]       act;
  logic [15:0]            b_pick;
  logic [32*LANES-1:0]    nxt_a, nxt_b;

  assign act    = wide ? '1 : LANES'(2'b11);
  assign grp_a  = wide ? (upper ? src_a[127:64] : src_a[63:0])
                       : {32'd0, upper ? src_a[63:32] : src_a[31:0]};
  assign grp_b  = wide ? (upper ? src_b[127:64] : src_b[63:0])
                       : {32'd0, upper ? src_b[63:32] : src_b[31:0]};
  assign b_pick = src_b[{idx, 4'b0000} +: 16];

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      nxt_a[32*i +: 32] = act[i] ? h2s(grp_a[16*i +: 16] ^ {sub, 15'd0}, ftz) : 32'd0;
      nxt_b[32*i +: 32] = act[i] ? h2s(indexed ? b_pick : grp_b[16*i +: 16], ftz) : 32'd0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      lane_mask <= '0;
      mul_a     <= '0;
      mul_b     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        lane_mask <= act;
        mul_a     <= nxt_a;
        mul_b     <= nxt_b;
      end
    end
  end
endmodule

// File: rtl/wmac_prep_chk.sv
module wmac_prep_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         wide,
  input logic         sub,
  input logic         indexed,
  input logic         out_valid,
  input logic [3:0]   lane_mask,
  input logic [127:0] mul_a,
  input logic [127:0] mul_b
);
  p_valid_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_mask_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> lane_mask == ($past(wide) ? 4'b1111 : 4'b0011));
  p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !lane_mask[2]) |-> (mul_a[127:64] == 64'd0 && mul_b[127:64] == 64'd0));
  p_broadcast_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && indexed) |=> (mul_b[31:0] == mul_b[63:32]));
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(mul_a) && $stable(mul_b) && $stable(lane_mask)));
  p_low_frac_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (mul_a[12:0] == 13'd0 && mul_b[12:0] == 13'd0));
endmodule

bind wmac_prep wmac_prep_chk chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .wide(wide), .sub(sub),
  .indexed(indexed), .out_valid(out_valid), .lane_mask(lane_mask),
  .mul_a(mul_a), .mul_b(mul_b)
);

// File: tb/wmac_prep_test.sv
module wmac_prep_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [127:0] src_a = '0, src_b = '0;
  logic         wide = 1'b0, upper = 1'b0, sub = 1'b0, indexed = 1'b0, ftz = 1'b0;
  logic [2:0]   idx = 3'd0;
  logic         out_valid;
  logic [3:0]   lane_mask;
  logic [127:0] mul_a, mul_b;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  wmac_prep uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_a(src_a), .src_b(src_b),
    .wide(wide), .upper(upper), .sub(sub), .indexed(indexed), .idx(idx), .ftz(ftz),
    .out_valid(out_valid), .lane_mask(lane_mask), .mul_a(mul_a), .mul_b(mul_b)
  );

  function automatic logic [31:0] ref_h2s(input logic [15:0] h, input logic fz);
    int e, m, ex;
    e = int'(h[14:10]);
    m = int'(h[9:0]);
    if (e == 31) return {h[15], 8'hff, h[9:0], 13'd0};
    if (e == 0 && m == 0) return {h[15], 31'd0};
    if (e == 0) begin
      if (fz) return {h[15], 31'd0};
      ex = -14;
      while (m < 1024) begin
        m = m * 2;
        ex = ex - 1;
      end
      return {h[15], 8'(ex + 127), 10'(m), 13'd0};
    end
    return {h[15], 8'(e - 15 + 127), h[9:0], 13'd0};
  endfunction

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_and_check(input string tag);
    logic [127:0] ea, eb;
    logic [3:0]   em;
    int           base;
    logic [15:0]  ha, hb;
    ea = '0;
    eb = '0;
    em = wide ? 4'b1111 : 4'b0011;
    base = wide ? (upper ? 64 : 0) : (upper ? 32 : 0);
    for (int i = 0; i < 4; i++) begin
      if (em[i]) begin
        ha = src_a[base + 16*i +: 16];
        if (sub) ha[15] = ~ha[15];
        hb = indexed ? src_b[16*int'(idx) +: 16] : src_b[base + 16*i +: 16];
        ea[32*i +: 32] = ref_h2s(ha, ftz);
        eb[32*i +: 32] = ref_h2s(hb, ftz);
      end
    end
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " R1 valid"}, {127'd0, out_valid}, 128'd1);
    check({tag, " R2 mask"}, {124'd0, lane_mask}, {124'd0, em});
    check({tag, " mul_a"}, mul_a, ea);
    check({tag, " mul_b"}, mul_b, eb);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [127:0] ha_s, hb_s, ma, mb;
    logic [3:0]   mk;
    repeat (3) @(negedge clk);
    check("R1 reset valid", {127'd0, out_valid}, 128'd0);
    check("R1 reset mask", {124'd0, lane_mask}, 128'd0);
    check("R1 reset mul_a", mul_a, 128'd0);
    check("R1 reset mul_b", mul_b, 128'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 R9: every half code, lanes R4 order, with and without flush
    wide = 1'b1;
    for (int fz = 0; fz < 2; fz++) begin
      ftz = fz[0];
      for (int k = 0; k < 8192; k++) begin
        upper = k[0];
        for (int i = 0; i < 4; i++) begin
          ha_s[16*i +: 16] = 16'(8*k + i);
          hb_s[16*i +: 16] = 16'(8*k + 4 + i);
        end
        src_a = upper ? {ha_s[63:0], 64'h5a5a_1234_ffff_0001} : {64'h3c00_7c00_8000_0400, ha_s[63:0]};
        src_b = upper ? {hb_s[63:0], 64'h1111_2222_3333_4444} : {64'h7e00_fc00_0001_8001, hb_s[63:0]};
        send_and_check(fz == 0 ? "R8 R9 sweep noftz" : "R8 R9 sweep ftz");
      end
    end

    // R3 R4 R5 R6 R7: configuration sweep with distinct elements
    ftz = 1'b0;
    for (int c = 0; c < 128; c++) begin
      wide = c[0];
      upper = c[1];
      sub = c[2];
      indexed = c[3];
      idx = 3'(c >> 4);
      for (int i = 0; i < 8; i++) begin
        src_a[16*i +: 16] = 16'(16'h3c00 + 16'(i * 129) + 16'(c * 7));
        src_b[16*i +: 16] = 16'(16'hc400 + 16'(i * 257) + 16'(c * 3));
      end
      send_and_check("R3 R4 R5 R6 R7 config");
      // R10: idle cycle with scrambled sources must not change outputs
      ma = mul_a;
      mb = mul_b;
      mk = lane_mask;
      src_a = ~src_a;
      src_b = {src_b[63:0], src_b[127:64]};
      wide = ~wide;
      @(negedge clk);
      check("R1 idle valid", {127'd0, out_valid}, 128'd0);
      check("R10 hold mul_a", mul_a, ma);
      check("R10 hold mul_b", mul_b, mb);
      check("R10 hold mask", {124'd0, lane_mask}, {124'd0, mk});
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule